// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This unit turns a core's word and byte memory operations into accesses to a byte-addressed, word-wide synchronous data store. For each request it adds a sign-extended 16-bit displacement to a 32-bit base value to form the effective address. It rejects word accesses that do not fall on a 4-byte boundary. It derives per-byte write strobes and routes store bytes onto the correct lanes. On a load it picks out the addressed byte and sign-extends it, or it returns the whole word.

The data store sits inside the unit as a plain byte-enabled RAM that can map onto block RAM. A request is presented for one clock cycle. One cycle later the unit shows the effective address and the misalignment flag. For a load that was accepted it also shows the read data with a valid strobe. The byte order inside a word is fixed at build time by a parameter.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. It appears on `rsp_addr` in the cycle after a request. The RAM word is selected by address bits [IDX_W+1:2], so adjacent words are 4 address units apart and higher address bits are ignored (aliases).
- R2: Op codes: 2'b00 load word, 2'b01 load byte, 2'b10 store word, 2'b11 store byte. A store word writes all 32 bits. A load word returns the whole stored word.
- R3: A word op whose effective address has bits [1:0] not 00 does not touch memory and produces no `rsp_valid`. It raises `rsp_misalign` for exactly the one cycle after the request.
- R4: Byte ops have no alignment restriction and never raise `rsp_misalign`.
- R5: A store byte changes only the addressed byte of its word. The other three bytes keep their values.
- R6: A load byte returns the selected byte sign-extended to 32 bits.
- R7: Lane order: with BIG_ENDIAN=0, address offset n maps to bits [8n+7:8n]. With BIG_ENDIAN=1, it maps to bits [31-8n:24-8n].
- R8: `rsp_valid` is high for exactly the one cycle after an accepted load and is low otherwise. After reset, `rsp_valid` and `rsp_misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data; low byte used by store byte |
| rsp_addr | output | 32 | Effective address of the previous request |
| rsp_misalign | output | 1 | Previous request was a misaligned word op |
| rsp_valid | output | 1 | `rsp_rdata` holds load data |
| rsp_rdata | output | 32 | Load result |

## Verification
The hardest case to reach from the ports is a suppressed misaligned store. It leaves no trace on any output except the flag, so the missing write must be shown indirectly. The bench first fills a word with a known pattern. It then issues misaligned store words that land on that word through both positive and negative displacements. An aligned load word afterwards must still return the original pattern. Two instances, one per byte order, receive identical stimulus, so each lane mapping is checked against explicit constants rather than against a shared formula.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_LDB = 2'b01,
    OP_STW = 2'b10,
    OP_STB = 2'b11
  } mem_op_e;

  function automatic logic op_is_store(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_byte(input logic [1:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] ea,
  output logic [LANE_W-1:0] lane,
  output logic              misalign,
  output logic              accept,
  output logic [LANES-1:0]  strobe
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    ea      = base + off_ext;
  end

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane = ~ea[LANE_W-1:0];
    end else begin : g_little
      assign lane = ea[LANE_W-1:0];
    end
  endgenerate

  always_comb begin
    misalign = valid && !op_is_byte(op) && (ea[LANE_W-1:0] != '0);
    accept   = valid && !misalign;
    if (op_is_byte(op)) strobe = LANES'(1) << lane;
    else                strobe = '1;
  end
endmodule

// File: rtl/lsu_byte_ram.sv
module lsu_byte_ram
  import lsu_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANES-1:0]  be,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < LANES; b++) begin
        if (be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    if (rd_en) rdata <= mem[idx];
  end

  // R2 R5
  strobe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (be == '1 || $onehot(be)));
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_go,
  input  logic              is_byte,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] ram_q,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              byte_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      byte_q    <= 1'b0;
      lane_q    <= '0;
    end else begin
      out_valid <= load_go;
      if (load_go) begin
        byte_q <= is_byte;
        lane_q <= lane;
      end
    end
  end

  always_comb begin
    sel = ram_q[8*lane_q +: 8];
    if (byte_q) out_data = {{(DATA_W-8){sel[7]}}, sel};
    else        out_data = ram_q;
  end

  // R8
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(load_go));

  // R6
  byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && byte_q) |-> (out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}}));
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int MEM_WORDS  = 256,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_misalign,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [ADDR_W-1:0] ea;
  logic [LANE_W-1:0] lane;
  logic              misalign, accept;
  logic [LANES-1:0]  strobe;
  logic [DATA_W-1:0] lane_wdata, ram_q;
  logic              wr_go, rd_go;

  lsu_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BIG_ENDIAN(BIG_ENDIAN)
  ) u_addr (
    .valid(req_valid), .op(req_op), .base(req_base), .offset(req_offset),
    .ea(ea), .lane(lane), .misalign(misalign), .accept(accept), .strobe(strobe)
  );

  always_comb begin
    if (op_is_byte(req_op)) lane_wdata = {LANES{req_wdata[7:0]}};
    else                    lane_wdata = req_wdata;
    wr_go = accept && op_is_store(req_op);
    rd_go = accept && !op_is_store(req_op);
  end

  lsu_byte_ram #(.WORDS(MEM_WORDS)) u_ram (
    .clk(clk), .rst(rst), .wr_en(wr_go), .rd_en(rd_go), .be(strobe),
    .idx(ea[IDX_W+1:2]), .wdata(lane_wdata), .rdata(ram_q)
  );

  lsu_load_extract u_ext (
    .clk(clk), .rst(rst), .load_go(rd_go), .is_byte(op_is_byte(req_op)),
    .lane(lane), .ram_q(ram_q), .out_valid(rsp_valid), .out_data(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_misalign <= 1'b0;
      rsp_addr     <= '0;
    end else begin
      rsp_misalign <= misalign;
      if (req_valid) rsp_addr <= ea;
    end
  end

  // R3
  flag_excludes_data_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_misalign && rsp_valid));

  // R3 R4
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_misalign |-> $past(req_valid && !op_is_byte(req_op)));

  // R3
  flag_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> !wr_go);
endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] addr_le, addr_be, data_le, data_be;
  logic        mis_le, mis_be, vld_le, vld_be;

  int n_checks = 0;
  int n_errs   = 0;

  logic [31:0] ref_le [256];
  logic [31:0] ref_be [256];

  always #4 clk = ~clk;

  lsu_lane_unit i_lsu_lane_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_addr(addr_le), .rsp_misalign(mis_le), .rsp_valid(vld_le), .rsp_rdata(data_le)
  );

  lsu_lane_unit #(.BIG_ENDIAN(1'b1)) i_lsu_lane_unit_be (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_addr(addr_be), .rsp_misalign(mis_be), .rsp_valid(vld_be), .rsp_rdata(data_be)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one request, then compare both instances with the reference model.
  task automatic issue(input logic [1:0] op, input logic [31:0] base,
                       input logic [15:0] off, input logic [31:0] wd, input string tag);
    logic [31:0] ea;
    logic [7:0]  idx;
    logic [1:0]  ln_le, ln_be;
    logic        bad;
    logic [31:0] e_le, e_be;
    ea    = base + {{16{off[15]}}, off};
    idx   = ea[9:2];
    ln_le = ea[1:0];
    ln_be = 2'd3 - ea[1:0];
    bad   = !op[0] && (ea[1:0] != 2'b00);
    e_le  = op[0] ? {{24{ref_le[idx][8*ln_le+7]}}, ref_le[idx][8*ln_le +: 8]} : ref_le[idx];
    e_be  = op[0] ? {{24{ref_be[idx][8*ln_be+7]}}, ref_be[idx][8*ln_be +: 8]} : ref_be[idx];
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (op[1] && !bad) begin
      if (op[0]) begin
        ref_le[idx][8*ln_le +: 8] = wd[7:0];
        ref_be[idx][8*ln_be +: 8] = wd[7:0];
      end else begin
        ref_le[idx] = wd;
        ref_be[idx] = wd;
      end
    end
    chk({tag, " R1 addr le"}, addr_le, ea);
    chk({tag, " R1 addr be"}, addr_be, ea);
    chk({tag, " R3 R4 flag le"}, {31'd0, mis_le}, {31'd0, bad});
    chk({tag, " R3 R4 flag be"}, {31'd0, mis_be}, {31'd0, bad});
    chk({tag, " R8 valid le"}, {31'd0, vld_le}, {31'd0, !op[1] && !bad});
    chk({tag, " R8 valid be"}, {31'd0, vld_be}, {31'd0, !op[1] && !bad});
    if (!op[1] && !bad) begin
      chk({tag, " R2 R6 data le"}, data_le, e_le);
      chk({tag, " R2 R6 data be"}, data_be, e_be);
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk({tag, " R8 idle valid"}, {30'd0, vld_le, vld_be}, 32'd0);
    chk({tag, " R3 idle flag"}, {30'd0, mis_le, mis_be}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R8 reset valid", {30'd0, vld_le, vld_be}, 32'd0);
    chk("R8 reset flag", {30'd0, mis_le, mis_be}, 32'd0);
  endtask

  task automatic t_words;
    issue(2'b10, 32'h0000_0100, 16'h0000, 32'hDEAD_BEEF, "sw base");
    issue(2'b10, 32'h0000_0108, 16'hFFFC, 32'h1234_5678, "sw negoff"); // 0x104
    issue(2'b00, 32'h0000_0100, 16'h0000, 32'h0, "lw w0");
    issue(2'b00, 32'h0000_00F0, 16'h0014, 32'h0, "lw w1");
    chk("R1 adjacent word", data_le, 32'h1234_5678);
    idle_check("words");
  endtask

  task automatic t_alias;
    issue(2'b10, 32'h0000_0000, 16'h0010, 32'h1122_3344, "sw low");
    issue(2'b00, 32'h8000_0400, 16'h0010, 32'h0, "lw alias");
    chk("R1 alias data", data_le, 32'h1122_3344);
  endtask

  task automatic t_misalign;
    issue(2'b10, 32'h0000_0200, 16'h0000, 32'hCAFE_F00D, "sw fill");
    issue(2'b10, 32'h0000_0200, 16'h0001, 32'hFFFF_FFFF, "sw mis1");
    issue(2'b10, 32'h0000_0206, 16'hFFFC, 32'h0000_0000, "sw mis2");
    idle_check("after mis");
    issue(2'b00, 32'h0000_0203, 16'h0000, 32'h0, "lw mis3");
    idle_check("after lw mis");
    issue(2'b00, 32'h0000_0200, 16'h0000, 32'h0, "lw keep");
    chk("R3 store suppressed", data_le, 32'hCAFE_F00D);
  endtask

  task automatic t_byte_store;
    issue(2'b10, 32'h0000_0300, 16'h0000, 32'h0000_0000, "sw clr");
    issue(2'b11, 32'h0000_0300, 16'h0000, 32'h0000_00AB, "sb off0");
    issue(2'b00, 32'h0000_0300, 16'h0000, 32'h0, "lw off0");
    chk("R7 le lane0", data_le, 32'h0000_00AB);
    chk("R7 be lane0", data_be, 32'hAB00_0000);
    issue(2'b11, 32'h0000_0303, 16'h0000, 32'h7777_77CD, "sb off3");
    issue(2'b11, 32'h0000_0304, 16'hFFFE, 32'h0000_0011, "sb off2");
    issue(2'b00, 32'h0000_0300, 16'h0000, 32'h0, "lw mix");
    chk("R5 R7 le mix", data_le, 32'hCD11_00AB);
    chk("R5 R7 be mix", data_be, 32'hAB00_11CD);
  endtask

  task automatic t_byte_load;
    issue(2'b10, 32'h0000_0310, 16'h0000, 32'h80_7F_01_FE, "sw bytes");
    for (int k = 0; k < 4; k++) begin
      issue(2'b01, 32'h0000_0310, 16'(k), 32'h0, "lb lane");
    end
    issue(2'b01, 32'h0000_0310, 16'h0000, 32'h0, "lb0");
    chk("R6 le sext", data_le, 32'hFFFF_FFFE);
    chk("R6 be sext", data_be, 32'hFFFF_FF80);
    issue(2'b01, 32'h0000_0312, 16'h0000, 32'h0, "lb2");
    chk("R6 le pos", data_le, 32'h0000_007F);
    chk("R6 be pos", data_be, 32'h0000_0001);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog R8 actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_le[i] = '0;
      ref_be[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_words();
    t_alias();
    t_misalign();
    t_byte_store();
    t_byte_load();
    idle_check("end");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule